// File: doc/BRIEF.md
# Memory Self-Test Controller with Failing-Address Capture

This controller exercises a small synchronous single-port RAM through its address, write-data, write-enable and read-enable lines. On a start request it latches a test mode and a seed. It then runs a fixed series of write passes and read passes. Each word that comes back is compared with the word the controller computed for that address.

Every returned word is also folded into a multiple-input signature register. A second register of the same kind folds the expected words. Once the run is over, a single comparison of the two registers decides pass or fail. Alongside the signature, a small capture list records each distinct failing address in the order it first failed. Repair logic can read this list later.

Two modes are available. The walking-bit mode moves a single set bit through every bit position, one full write-then-read sweep per position. The address-pair mode fills the array and then reads it back in an interleaved order that alternates between an address and its bitwise complement. This order stresses the address-switching paths.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, busy, done, pass, ram_we_o, ram_re_o, fail_count_o, fail_overflow_o and signature_o are all zero.
- R2: A start seen while idle or done begins a run and latches mode_i and seed_i. busy stays high from the next cycle until the run ends, and done then stays high until the next accepted start. A start while busy is ignored, together with any mode or seed change at that moment.
- R3: Walking mode (mode_i = 0) runs DW passes. Pass p writes addresses 0 to N-1 in ascending order, each address a with the word (1 << ((p + a) mod DW)) XOR seed. It then reads addresses 0 to N-1 in ascending order. busy lasts 2·N·DW + 1 cycles.
- R4: Pair mode (mode_i = 1) writes addresses 0 to N-1 in ascending order, each with seed XOR {a, a} (the address replicated across the word). It then makes 2N reads; read k addresses i = k/2 when k is even and ~i when k is odd. busy lasts 3N + 1 cycles.
- R5: Read data is taken one cycle after the read address. A word mismatches when it differs from the word last written to that address.
- R6: The signature updates once per returned word as s' = (s << 1) XOR (s[DW-1] ? POLY : 0) XOR word, with POLY = 8'h1D by default. pass is high only while done and only when the signature equals the same fold taken over the expected words.
- R7: Each distinct failing address is stored once, in order of its first failure. Entry i sits at fail_log_o[i·AW +: AW]. A stored entry is never overwritten, and a repeat failure at a stored address changes nothing.
- R8: fail_count_o holds the number of stored entries and saturates at 5. fail_overflow_o is set when a new distinct failing address appears while 5 entries are already stored.
- R9: An accepted start clears the signature, the count, the overflow flag and the log, all on the same edge that begins the run.
- R10: The seed XORs into every written and expected word in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| mode_i | input | 1 | Test select: 0 walking bit, 1 address pair |
| seed_i | input | DW | Data seed XORed into all patterns |
| ram_addr_o | output | AW | RAM address |
| ram_wdata_o | output | DW | RAM write data |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_rdata_i | input | DW | RAM read data, one cycle after the read |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until the next start |
| pass_o | output | 1 | Signature matches the reference (valid with done) |
| signature_o | output | DW | Signature of the returned words |
| fail_count_o | output | 3 | Stored failing addresses, saturating at 5 |
| fail_overflow_o | output | 1 | More distinct failing addresses than slots |
| fail_log_o | output | 5·AW | Failing-address entries, entry 0 in the low bits |

## Verification
The hardest states to reach are log saturation and overflow. Reaching them needs six or more distinct addresses that fail, in a known order, while repeat failures at stored addresses must not consume slots. A RAM model in the bench forces one bit to a chosen value on a mask of addresses. Because the expected value of that bit depends on the address, the seed and the pass, picking the stuck polarity against each pattern yields exactly one, five or more than five distinct failures. In walking mode, each faulty address fails in several passes, which exercises duplicate suppression. A start pulse with a changed mode and seed is injected in the middle of a run to show that it is ignored.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WRITE = 3'd1,
        S_READ  = 3'd2,
        S_FLUSH = 3'd3,
        S_DONE  = 3'd4
    } seq_state_e;

    typedef enum logic {
        MODE_WALK = 1'b0,
        MODE_PAIR = 1'b1
    } test_mode_e;

endpackage

// File: rtl/mbist_seq.sv
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [DW-1:0] seed_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          clear_o,
    output logic [AW-1:0] ram_addr_o,
    output logic [DW-1:0] ram_wdata_o,
    output logic          ram_we_o,
    output logic          ram_re_o,
    output logic          chk_valid_o,
    output logic [AW-1:0] chk_addr_o,
    output logic [DW-1:0] chk_exp_o
);
    localparam int N   = 1 << AW;
    localparam int PW  = $clog2(DW);
    localparam int SW  = AW + 1;
    localparam int REP = DW / AW + 1;

    typedef struct packed {
        seq_state_e    st;
        logic          mode;
        logic [DW-1:0] seed;
        logic [PW-1:0] pass;
        logic [SW-1:0] step;
        logic          chk_valid;
        logic [AW-1:0] chk_addr;
        logic [DW-1:0] chk_exp;
    } seq_t;

    seq_t q, d;

    function automatic logic [DW-1:0] walk_word(logic [PW-1:0] p, logic [AW-1:0] a,
                                                logic [DW-1:0] s);
        logic [PW-1:0] idx;
        idx = p + PW'(a);
        return (DW'(1) << idx) ^ s;
    endfunction

    function automatic logic [DW-1:0] pair_word(logic [AW-1:0] a, logic [DW-1:0] s);
        return s ^ DW'({REP{a}});
    endfunction

    logic          start_ok, last_wr, last_rd;
    logic [AW-1:0] pair_idx, addr_c;
    logic [DW-1:0] word_c;

    always_comb begin
        start_ok = start_i && (q.st == S_IDLE || q.st == S_DONE);
        pair_idx = q.step[AW:1];
        if (q.st == S_READ && q.mode == MODE_PAIR)
            addr_c = q.step[0] ? ~pair_idx : pair_idx;
        else
            addr_c = q.step[AW-1:0];
        word_c  = (q.mode == MODE_PAIR) ? pair_word(addr_c, q.seed)
                                        : walk_word(q.pass, addr_c, q.seed);
        last_wr = (q.step == SW'(N - 1));
        last_rd = (q.mode == MODE_PAIR) ? (q.step == SW'(2 * N - 1)) : last_wr;

        d           = q;
        d.chk_valid = (q.st == S_READ);
        d.chk_addr  = addr_c;
        d.chk_exp   = word_c;
        case (q.st)
            S_IDLE, S_DONE: begin
                if (start_ok) begin
                    d.st   = S_WRITE;
                    d.mode = mode_i;
                    d.seed = seed_i;
                    d.pass = '0;
                    d.step = '0;
                end
            end
            S_WRITE: begin
                if (last_wr) begin
                    d.st   = S_READ;
                    d.step = '0;
                end else begin
                    d.step = q.step + SW'(1);
                end
            end
            S_READ: begin
                if (last_rd) begin
                    if (q.mode == MODE_WALK && q.pass != PW'(DW - 1)) begin
                        d.pass = q.pass + PW'(1);
                        d.step = '0;
                        d.st   = S_WRITE;
                    end else begin
                        d.st = S_FLUSH;
                    end
                end else begin
                    d.step = q.step + SW'(1);
                end
            end
            S_FLUSH: d.st = S_DONE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.st == S_WRITE) || (q.st == S_READ) || (q.st == S_FLUSH);
    assign done_o      = (q.st == S_DONE);
    assign clear_o     = start_ok;
    assign ram_addr_o  = addr_c;
    assign ram_wdata_o = word_c;
    assign ram_we_o    = (q.st == S_WRITE);
    assign ram_re_o    = (q.st == S_READ);
    assign chk_valid_o = q.chk_valid;
    assign chk_addr_o  = q.chk_addr;
    assign chk_exp_o   = q.chk_exp;

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(q.mode) && $stable(q.seed) && busy_o || done_o));

    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R2
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R3
    ram_access_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o || ram_re_o) |-> (busy_o && !(ram_we_o && ram_re_o)));

endmodule

// File: rtl/mbist_misr.sv
module mbist_misr #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   POLY = 8'h1D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         en_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] sig_o
);
    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        if (clear_i)
            sig_d = '0;
        else if (en_i)
            sig_d = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0) ^ data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig_o = sig_q;

    // R9
    sig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sig_o == '0));

endmodule

// File: rtl/mbist_faillog.sv
module mbist_faillog #(
    parameter int AW    = 4,
    parameter int DEPTH = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  hit_i,
    input  logic [AW-1:0]         addr_i,
    output logic [DEPTH*AW-1:0]   log_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                  ovf_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [CW-1:0]            cnt;
        logic                     ovf;
    } log_t;

    log_t q, d;
    logic dup;

    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (CW'(i) < q.cnt && q.ent[i] == addr_i) dup = 1'b1;

        d = q;
        if (clear_i) begin
            d = '0;
        end else if (hit_i && !dup) begin
            if (q.cnt < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++)
                    if (CW'(i) == q.cnt) d.ent[i] = addr_i;
                d.cnt = q.cnt + CW'(1);
            end else begin
                d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign log_o   = q.ent;
    assign count_o = q.cnt;
    assign ovf_o   = q.ovf;

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // R8
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (count_o == CW'(DEPTH)));

    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
        // R7
        entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q.cnt > CW'(g) && !clear_i) |=> $stable(q.ent[g]));
    end

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl #(
    parameter int            AW    = 4,
    parameter int            DW    = 8,
    parameter logic [DW-1:0] POLY  = 8'h1D,
    parameter int            LOG_N = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        mode_i,
    input  logic [DW-1:0]               seed_i,
    output logic [AW-1:0]               ram_addr_o,
    output logic [DW-1:0]               ram_wdata_o,
    output logic                        ram_we_o,
    output logic                        ram_re_o,
    input  logic [DW-1:0]               ram_rdata_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        pass_o,
    output logic [DW-1:0]               signature_o,
    output logic [$clog2(LOG_N+1)-1:0]  fail_count_o,
    output logic                        fail_overflow_o,
    output logic [LOG_N*AW-1:0]         fail_log_o
);
    logic          clear, chk_valid, mismatch;
    logic [AW-1:0] chk_addr;
    logic [DW-1:0] chk_exp;
    logic [DW-1:0] misr_in  [2];
    logic [DW-1:0] misr_sig [2];

    mbist_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .seed_i      (seed_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .clear_o     (clear),
        .ram_addr_o  (ram_addr_o),
        .ram_wdata_o (ram_wdata_o),
        .ram_we_o    (ram_we_o),
        .ram_re_o    (ram_re_o),
        .chk_valid_o (chk_valid),
        .chk_addr_o  (chk_addr),
        .chk_exp_o   (chk_exp)
    );

    assign mismatch   = chk_valid && (ram_rdata_i != chk_exp);
    assign misr_in[0] = ram_rdata_i;
    assign misr_in[1] = chk_exp;

    for (genvar g = 0; g < 2; g++) begin : g_misr
        mbist_misr #(.W(DW), .POLY(POLY)) u_misr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .en_i    (chk_valid),
            .data_i  (misr_in[g]),
            .sig_o   (misr_sig[g])
        );
    end

    mbist_faillog #(.AW(AW), .DEPTH(LOG_N)) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .hit_i   (mismatch),
        .addr_i  (chk_addr),
        .log_o   (fail_log_o),
        .count_o (fail_count_o),
        .ovf_o   (fail_overflow_o)
    );

    assign signature_o = misr_sig[0];
    assign pass_o      = done_o && (misr_sig[0] == misr_sig[1]);

    // R5
    mismatch_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> $past(ram_re_o));

endmodule

// File: tb/mbist_ctrl_bench.sv
module mbist_ctrl_bench;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 16;
    localparam int LN = 5;

    typedef struct packed {
        logic        mode;
        logic [7:0]  seed;
        logic [15:0] fmask;
        logic [2:0]  fbit;
        logic        fval;
        logic [2:0]  exp_cnt;
        logic        exp_ovf;
        logic        inject;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 16'h0000, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0},
        '{1'b1, 8'hA5, 16'h0000, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0},
        '{1'b0, 8'h00, 16'h0008, 3'd5, 1'b0, 3'd1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 16'h00FF, 3'd0, 1'b1, 3'd5, 1'b1, 1'b0},
        '{1'b1, 8'h00, 16'h0003, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0},
        '{1'b1, 8'hFF, 16'h0003, 3'd0, 1'b1, 3'd1, 1'b0, 1'b0},
        '{1'b1, 8'h00, 16'h003F, 3'd7, 1'b1, 3'd5, 1'b1, 1'b0},
        '{1'b0, 8'h00, 16'h8000, 3'd2, 1'b0, 3'd1, 1'b0, 1'b0},
        '{1'b1, 8'h00, 16'h001F, 3'd7, 1'b1, 3'd5, 1'b0, 1'b0},
        '{1'b0, 8'h3C, 16'h0400, 3'd4, 1'b1, 3'd1, 1'b0, 1'b0},
        '{1'b0, 8'h00, 16'h0000, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [7:0]    seed_i = '0;
    logic [3:0]    ram_addr;
    logic [7:0]    ram_wdata, ram_rdata;
    logic          ram_we, ram_re, busy, done, pass;
    logic [7:0]    signature;
    logic [2:0]    fcount;
    logic          fovf;
    logic [19:0]   flog;

    always #4 clk = ~clk;

    mbist_ctrl u_mbist_ctrl (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
        .seed_i (seed_i), .ram_addr_o (ram_addr), .ram_wdata_o (ram_wdata),
        .ram_we_o (ram_we), .ram_re_o (ram_re), .ram_rdata_i (ram_rdata),
        .busy_o (busy), .done_o (done), .pass_o (pass), .signature_o (signature),
        .fail_count_o (fcount), .fail_overflow_o (fovf), .fail_log_o (flog)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // fault configuration and reference model
    logic [15:0] cur_mask = '0;
    logic [2:0]  cur_bit = '0;
    logic        cur_val = 1'b0;
    logic        cur_mode = 1'b0;
    logic [7:0]  cur_seed = '0;
    logic        model_clr = 1'b0;

    logic [7:0] mem [N];
    logic [7:0] m_sig, m_ref;
    logic [3:0] m_log [LN];
    int m_cnt, m_ovf, wr_idx, rd_idx, wr_err, rd_err;

    function automatic logic [7:0] fold(logic [7:0] s, logic [7:0] w);
        return {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00) ^ w;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) mem[i] = '0;
        ram_rdata = '0;
        m_sig = '0; m_ref = '0; m_cnt = 0; m_ovf = 0;
        wr_idx = 0; rd_idx = 0; wr_err = 0; rd_err = 0;
    end

    always @(posedge clk) begin
        if (model_clr) begin
            m_sig = '0; m_ref = '0; m_cnt = 0; m_ovf = 0;
            wr_idx = 0; rd_idx = 0; wr_err = 0; rd_err = 0;
        end else begin
            if (ram_we) begin
                logic [3:0] ea;
                logic [7:0] ed;
                if (cur_mode) begin
                    ea = 4'(wr_idx);
                    ed = cur_seed ^ {ea, ea};
                end else begin
                    ea = 4'(wr_idx % N);
                    ed = (8'h01 << ((wr_idx / N + int'(ea)) % 8)) ^ cur_seed;
                end
                if (ram_addr != ea || ram_wdata != ed) wr_err++;
                mem[ram_addr] <= ram_wdata;
                wr_idx++;
            end
            if (ram_re) begin
                logic [3:0] ra;
                logic [7:0] good, act;
                bit seen;
                if (cur_mode) begin
                    ra = 4'(rd_idx / 2);
                    if (rd_idx % 2 == 1) ra = ~ra;
                end else begin
                    ra = 4'(rd_idx % N);
                end
                if (ram_addr != ra) rd_err++;
                good = mem[ram_addr];
                act  = good;
                if (cur_mask[ram_addr]) act[cur_bit] = cur_val;
                ram_rdata <= act;
                m_sig = fold(m_sig, act);
                m_ref = fold(m_ref, good);
                if (act != good) begin
                    seen = 1'b0;
                    for (int i = 0; i < LN; i++)
                        if (i < m_cnt && m_log[i] == ram_addr) seen = 1'b1;
                    if (!seen) begin
                        if (m_cnt < LN) begin
                            m_log[m_cnt] = ram_addr;
                            m_cnt++;
                        end else begin
                            m_ovf = 1;
                        end
                    end
                end
                rd_idx++;
            end
        end
    end

    task automatic run_vec(input vec_t v, input int idx);
        int busy_cnt = 0;
        int wd = 0;
        int exp_busy = v.mode ? (3 * N + 1) : (2 * N * DW + 1);
        int exp_rd   = v.mode ? (2 * N) : (N * DW);
        @(negedge clk);
        cur_mask = v.fmask; cur_bit = v.fbit; cur_val = v.fval;
        cur_mode = v.mode;  cur_seed = v.seed;
        mode_i = v.mode; seed_i = v.seed; start_i = 1'b1; model_clr = 1'b1;
        @(negedge clk);
        start_i = 1'b0; model_clr = 1'b0;
        // R9: start clears results on the accepting edge; R2 busy/done
        check(busy == 1'b1 && done == 1'b0, "R2 busy after start", {busy, done}, 2);
        check(signature == 8'h00, "R9 signature cleared", signature, 0);
        check(fcount == 3'd0 && fovf == 1'b0, "R9 log cleared", {fovf, fcount}, 0);
        while (!done && wd < 5000) begin
            if (busy) busy_cnt++;
            if (v.inject && busy_cnt == 20) begin
                start_i = 1'b1; mode_i = ~v.mode; seed_i = ~v.seed;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            wd++;
        end
        start_i = 1'b0;
        check(wd < 5000, "R2 watchdog", wd, idx);
        // R3 / R4 length and ordering, R10 seed in patterns
        check(busy_cnt == exp_busy, v.mode ? "R4 busy length" : "R3 busy length",
              busy_cnt, exp_busy);
        check(wr_err == 0, v.mode ? "R4 R10 write stream" : "R3 R10 write stream", wr_err, 0);
        check(rd_err == 0 && rd_idx == exp_rd, "R5 read order/count", rd_idx, exp_rd);
        // R6 signature and pass
        check(signature == m_sig, "R6 signature", signature, m_sig);
        check(pass == (m_sig == m_ref), "R6 pass", pass, (m_sig == m_ref));
        if (v.fmask == 16'h0)
            check(pass == 1'b1, "R6 fault-free pass", pass, 1);
        // R7 / R8 log
        check(int'(fcount) == m_cnt && fcount == v.exp_cnt, "R8 fail count", fcount, v.exp_cnt);
        check(int'(fovf) == m_ovf && fovf == v.exp_ovf, "R8 overflow", fovf, v.exp_ovf);
        for (int i = 0; i < LN; i++)
            if (i < m_cnt)
                check(flog[i*AW +: AW] == m_log[i], "R7 log entry", flog[i*AW +: AW], m_log[i]);
    endtask

    initial begin
        logic [7:0] sig_hold;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0 && pass == 0, "R1 status at reset", {busy, done, pass}, 0);
        check(ram_we == 0 && ram_re == 0, "R1 ram idle at reset", {ram_we, ram_re}, 0);
        check(fcount == 0 && fovf == 0 && signature == 0, "R1 results at reset",
              {fovf, fcount, signature}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
        // R2: done held, results frozen while idle
        sig_hold = signature;
        repeat (10) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R2 done held", {done, busy}, 2);
        check(signature == sig_hold, "R2 signature held", signature, sig_hold);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule